// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a real-time clock core. It keeps seconds, minutes, hours, day of month, month and a two-digit year, all in packed BCD. An external enable pulses at 32.768 kHz, and a prescaler turns those pulses into one calendar step per second. The calendar rolls over at the correct month lengths, and February gets a 29th day in every year whose two-digit value is divisible by four.

Software reaches the block through a byte-wide register port, with one access per clock cycle. Reads are combinational from the address. Writes take effect at the next edge. The port has no valid/ready handshake and never applies back-pressure: every access completes in the cycle it is presented. This leaves timing to software, and software must respect the busy window. Just before each one-second step, a status bit warns that the time fields are about to change.

A complete six-field alarm is compared against the whole calendar, with no masked fields. Sticky event flags record second, minute, hour and day boundaries and the alarm match. Two interrupt outputs combine those flags with enable bits.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the time reads 00:00:00 on day 0x01, month 0x01, year 0x00. The control, status and interrupt-enable registers read 0x00, and both interrupt outputs are low.
- R2: Control bit 0 is the run bit. While it is 1, every TICKS_PER_SEC-th tick enable advances the time by one second, and status bit 1 reads 1. While it is 0, the time fields and the prescaler hold and status bit 1 reads 0.
- R3: Seconds step 0x59 to 0x00 and carry into minutes. Minutes step 0x59 to 0x00 and carry into hours. Hours step 0x23 to 0x00 and carry into the day, so the clock runs in 24-hour form only.
- R4: The day steps from the month's last day back to 0x01 and carries into the month. Months 0x04, 0x06, 0x09 and 0x11 end at 0x30. Month 0x02 ends at 0x29 when the binary year is divisible by 4 and at 0x28 otherwise. All other months end at 0x31. Month 0x12 steps to 0x01 and carries into the year, and year 0x99 steps to 0x00.
- R5: Status bit 0 (busy) is 1 while running during the last tick-enable period before each one-second step, and 0 at all other times, including whenever the clock is stopped.
- R6: Status bits 2, 3, 4 and 5 are sticky flags. They are set on each second step, on a step where the seconds wrap, on a step where the minutes wrap, and on a step where the hours wrap, respectively. Writing 1 to a bit clears it. A set in the same cycle wins over the clear.
- R7: Status bit 6 is set on the one-second step whose new time equals all six alarm fields. A difference in any single field, the year included, prevents the match.
- R8: The alarm flag stays set until a 1 is written to status bit 6. Writing 0 there leaves it set.
- R9: The timer interrupt output equals status bit 2 AND interrupt-enable bit 2. The alarm interrupt output equals status bit 6 AND interrupt-enable bit 3.
- R10: A write to a time field loads that field at once and leaves the prescaler phase unchanged, so the next step arrives at the same tick count as it would have without the write.
- R11: Control bit 3 (the 12-hour select) ignores writes and always reads 0.
- R12: The time fields sit at byte addresses 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14, in the order seconds, minutes, hours, day, month, year. The alarm fields sit at 0x20 to 0x34 in the same order. Control is at 0x40, status at 0x44 and interrupt-enable at 0x48. Any other address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when 1, read when 0 |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq_timer | output | 1 | Per-second interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The bench builds the core with TICKS_PER_SEC set to 4 instead of 32768. One calendar step then costs four tick enables, so every rollover can be reached within a few hundred cycles. These include leap and non-leap February, the 30-day and 31-day month ends, the year wrap, alarm hits and near misses, and the prescaler phase across a time write. The same small divider makes the busy window a single visible tick period that the bench can land on exactly.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mo;
    logic [7:0] dy;
    logic [7:0] hr;
    logic [7:0] mi;
    logic [7:0] se;
  } rtc_time_t;

  localparam int NUM_FIELDS = 6;

  localparam logic [7:0] OFS_CTRL = 8'h40;
  localparam logic [7:0] OFS_STAT = 8'h44;
  localparam logic [7:0] OFS_IEN  = 8'h48;

  // Increment a BCD byte, wrapping from top back to bottom.
  function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                          input logic [7:0] top,
                                          input logic [7:0] bottom);
    if (v == top)            return bottom;
    else if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    else                     return v + 8'h01;
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
  endfunction

  // Last day of the month, in BCD.
  function automatic logic [7:0] month_last_day(input logic [7:0] mo,
                                                input logic [7:0] yr);
    logic [6:0] ybin;
    ybin = bcd_to_bin(yr);
    case (mo)
      8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // Reset value of a time field: day and month start at 1.
  function automatic logic [7:0] field_reset(input int idx);
    return (idx == 3 || idx == 4) ? 8'h01 : 8'h00;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick_en,
  output logic busy,
  output logic sec_pulse
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (run && tick_en) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy      = run && (cnt_q == LAST);
  assign sec_pulse = busy && tick_en;
endmodule

// File: rtl/rtc_cal_next.sv
module rtc_cal_next
  import rtc_pkg::*;
(
  input  rtc_time_t cur,
  output rtc_time_t nxt,
  output logic      wrap_sec,
  output logic      wrap_min,
  output logic      wrap_hr
);
  logic [7:0] last_day;
  logic       wrap_day;
  logic       wrap_mon;

  always_comb begin
    last_day = month_last_day(cur.mo, cur.yr);
    wrap_sec = (cur.se == 8'h59);
    wrap_min = wrap_sec && (cur.mi == 8'h59);
    wrap_hr  = wrap_min && (cur.hr == 8'h23);
    wrap_day = wrap_hr  && (cur.dy == last_day);
    wrap_mon = wrap_day && (cur.mo == 8'h12);

    nxt    = cur;
    nxt.se = bcd_step(cur.se, 8'h59, 8'h00);
    if (wrap_sec) nxt.mi = bcd_step(cur.mi, 8'h59, 8'h00);
    if (wrap_min) nxt.hr = bcd_step(cur.hr, 8'h23, 8'h00);
    if (wrap_hr)  nxt.dy = bcd_step(cur.dy, last_day, 8'h01);
    if (wrap_day) nxt.mo = bcd_step(cur.mo, 8'h12, 8'h01);
    if (wrap_mon) nxt.yr = bcd_step(cur.yr, 8'h99, 8'h00);
  end
endmodule

// File: rtl/rtc_field_reg.sv
module rtc_field_reg #(
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic [7:0] ld_val,
  input  logic       step,
  input  logic [7:0] step_val,
  output logic [7:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST_VAL;
    else if (ld)   q <= ld_val;
    else if (step) q <= step_val;
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_timer,
  output logic              irq_alarm
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IEN);

  logic                       run_q;
  logic                       ie_tmr_q, ie_alm_q;
  logic [4:0]                 flags_q, flags_d;
  logic                       busy, sec_pulse;
  logic [NUM_FIELDS-1:0][7:0] tq, aq, nxt_arr;
  rtc_time_t                  cur, nxt, alm;
  logic                       wrap_sec, wrap_min, wrap_hr;
  logic                       alm_hit;

  // address decode
  logic       wr_hit, in_low, win_time, win_alarm;
  logic [2:0] fidx;
  logic       time_wr;

  assign wr_hit    = bus_sel && bus_wr;
  assign fidx      = bus_addr[4:2];
  assign in_low    = (bus_addr[ADDR_W-1:6] == '0) && (bus_addr[1:0] == 2'b00)
                     && (fidx < 3'd6);
  assign win_time  = in_low && !bus_addr[5];
  assign win_alarm = in_low &&  bus_addr[5];
  assign time_wr   = wr_hit && win_time;

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .tick_en  (tick_en),
    .busy     (busy),
    .sec_pulse(sec_pulse)
  );

  assign cur = tq;
  assign alm = aq;

  rtc_cal_next u_next (
    .cur     (cur),
    .nxt     (nxt),
    .wrap_sec(wrap_sec),
    .wrap_min(wrap_min),
    .wrap_hr (wrap_hr)
  );

  assign nxt_arr = nxt;
  assign alm_hit = (nxt == alm);

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    rtc_field_reg #(.RST_VAL(field_reset(i))) u_time (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (time_wr && (fidx == 3'(i))),
      .ld_val  (bus_wdata),
      .step    (sec_pulse),
      .step_val(nxt_arr[i]),
      .q       (tq[i])
    );
    rtc_field_reg #(.RST_VAL(8'h00)) u_alarm (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (wr_hit && win_alarm && (fidx == 3'(i))),
      .ld_val  (bus_wdata),
      .step    (1'b0),
      .step_val(8'h00),
      .q       (aq[i])
    );
  end

  // flags: [0]=second [1]=minute [2]=hour [3]=day [4]=alarm
  always_comb begin
    flags_d = flags_q;
    if (wr_hit && bus_addr == A_STAT) flags_d = flags_d & ~bus_wdata[6:2];
    if (sec_pulse) flags_d = flags_d | {alm_hit, wrap_hr, wrap_min, wrap_sec, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      ie_tmr_q <= 1'b0;
      ie_alm_q <= 1'b0;
      flags_q  <= '0;
    end else begin
      flags_q <= flags_d;
      if (wr_hit && bus_addr == A_CTRL) run_q <= bus_wdata[0];
      if (wr_hit && bus_addr == A_IEN) begin
        ie_tmr_q <= bus_wdata[2];
        ie_alm_q <= bus_wdata[3];
      end
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (win_time)                bus_rdata = tq[fidx];
    else if (win_alarm)          bus_rdata = aq[fidx];
    else if (bus_addr == A_CTRL) bus_rdata = {7'b0, run_q};
    else if (bus_addr == A_STAT) bus_rdata = {1'b0, flags_q, run_q, busy};
    else if (bus_addr == A_IEN)  bus_rdata = {4'b0, ie_alm_q, ie_tmr_q, 2'b00};
  end

  assign irq_timer = ie_tmr_q && flags_q[0];
  assign irq_alarm = ie_alm_q && flags_q[4];
endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       busy,
  input logic       sec_pulse,
  input logic       time_wr,
  input logic [7:0] sec,
  input logic [4:0] flags,
  input logic       irq_alarm
);
  assert_busy_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run);

  assert_frozen_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !time_wr) |=> $stable(sec));

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !time_wr && sec == 8'h59) |=> (sec == 8'h00));

  assert_sec_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> flags[0]);

  assert_alarm_on_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[4]) |-> $past(sec_pulse));

  assert_irq_alarm_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_alarm |-> flags[4]);
endmodule

bind rtc_calendar_core rtc_calendar_core_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run_q),
  .busy     (busy),
  .sec_pulse(sec_pulse),
  .time_wr  (time_wr),
  .sec      (tq[0]),
  .flags    (flags_q),
  .irq_alarm(irq_alarm)
);

// File: tb/rtc_calendar_core_tb_top.sv
module rtc_calendar_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_timer, irq_alarm;

  always #4 clk = ~clk;

  rtc_calendar_core #(.TICKS_PER_SEC(4), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_timer(irq_timer), .irq_alarm(irq_alarm)
  );

  typedef struct {
    bit         pins;
    logic [7:0] addr;
    logic [7:0] exp;
    logic [7:0] mask;
    string      tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int   checks = 0;
  int   errs = 0;
  logic chk_req = 1'b0;
  bit   done = 1'b0;

  // monitor: pops one expectation per request and compares
  always @(negedge clk) begin
    if (chk_req && sb_q.size() > 0) begin
      sb_item_t it;
      logic [7:0] act;
      it  = sb_q.pop_front();
      act = it.pins ? {6'b0, irq_timer, irq_alarm} : bus_rdata;
      checks++;
      if ((act & it.mask) != (it.exp & it.mask)) begin
        errs++;
        $display("FAIL %s addr=%02h actual=%02h expected=%02h mask=%02h",
                 it.tag, it.addr, act, it.exp, it.mask);
      end
    end
  end

  task automatic push_chk(input bit pins, input logic [7:0] a,
                          input logic [7:0] e, input logic [7:0] m,
                          input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.pins = pins; it.addr = a; it.exp = e; it.mask = m; it.tag = tag;
    sb_q.push_back(it);
    chk_req = 1'b1;
    @(posedge clk); #1;
    chk_req = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    push_chk(1'b0, a, e, 8'hFF, tag);
  endtask

  task automatic rdm(input logic [7:0] a, input logic [7:0] e,
                     input logic [7:0] m, input string tag);
    push_chk(1'b0, a, e, m, tag);
  endtask

  task automatic pins(input logic [1:0] e, input string tag);
    push_chk(1'b1, 8'h00, {6'b0, e}, 8'h03, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1;
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick_en = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] yr, input logic [7:0] mo,
                          input logic [7:0] dy, input logic [7:0] hr,
                          input logic [7:0] mi, input logic [7:0] se);
    wr(8'h14, yr); wr(8'h10, mo); wr(8'h0C, dy);
    wr(8'h08, hr); wr(8'h04, mi); wr(8'h00, se);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, 8'h00, "R1 seconds");
    rd(8'h08, 8'h00, "R1 hours");
    rd(8'h0C, 8'h01, "R1 day");
    rd(8'h10, 8'h01, "R1 month");
    rd(8'h14, 8'h00, "R1 year");
    rd(8'h40, 8'h00, "R1 control");
    rd(8'h44, 8'h00, "R1 status");
    rd(8'h48, 8'h00, "R1 irq enable");
    pins(2'b00, "R1 irq pins");

    // R2 stopped clock ignores ticks
    ticks(8);
    rd(8'h00, 8'h00, "R2 stopped seconds hold");

    // R11 12-hour select ignored, R2 running bit
    wr(8'h40, 8'h09);
    rd(8'h40, 8'h01, "R11 control bit3 reads 0");
    rd(8'h44, 8'h02, "R2 status running");

    // R5 busy in last tick period
    ticks(3);
    rd(8'h44, 8'h03, "R5 busy before step");
    rd(8'h00, 8'h00, "R2 no step yet");
    ticks(1);
    rd(8'h00, 8'h01, "R2 one second step");
    rd(8'h44, 8'h06, "R6 second flag set, R5 busy low");
    wr(8'h44, 8'h04);
    rd(8'h44, 8'h02, "R6 second flag cleared");

    // R10 write keeps prescaler phase
    ticks(2);
    wr(8'h00, 8'h30);
    rd(8'h00, 8'h30, "R10 seconds loaded");
    ticks(2);
    rd(8'h00, 8'h31, "R10 step at unchanged phase");

    // R3 / R4 non-leap February end
    wr(8'h44, 8'h7C);
    set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    ticks(4);
    rd(8'h00, 8'h00, "R3 seconds wrap");
    rd(8'h04, 8'h00, "R3 minutes wrap");
    rd(8'h08, 8'h00, "R3 hours wrap");
    rd(8'h0C, 8'h01, "R4 day after 28 Feb non-leap");
    rd(8'h10, 8'h03, "R4 month after Feb");
    rd(8'h14, 8'h23, "R4 year unchanged");
    rd(8'h44, 8'h3E, "R6 all boundary flags");

    // R4 leap February
    set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    ticks(4);
    rd(8'h0C, 8'h29, "R4 leap day 29");
    rd(8'h10, 8'h02, "R4 leap month stays Feb");

    // R4 30-day month
    set_time(8'h24, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    ticks(4);
    rd(8'h0C, 8'h01, "R4 day after 30 Apr");
    rd(8'h10, 8'h05, "R4 month after Apr");

    // R4 year wrap
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    ticks(4);
    rd(8'h0C, 8'h01, "R4 new year day");
    rd(8'h10, 8'h01, "R4 new year month");
    rd(8'h14, 8'h00, "R4 year 99 wraps to 00");

    // R7 / R9 / R12 alarm
    wr(8'h20, 8'h05); wr(8'h24, 8'h00); wr(8'h28, 8'h00);
    wr(8'h2C, 8'h01); wr(8'h30, 8'h01); wr(8'h34, 8'h00);
    rd(8'h20, 8'h05, "R12 alarm seconds readback");
    rd(8'h2C, 8'h01, "R12 alarm day readback");
    wr(8'h48, 8'h08);
    wr(8'h44, 8'h7C);
    ticks(16);
    rd(8'h00, 8'h04, "R7 time before alarm");
    rdm(8'h44, 8'h00, 8'h40, "R7 no flag before match");
    pins(2'b00, "R9 alarm irq low before match");
    ticks(4);
    rdm(8'h44, 8'h40, 8'h40, "R7 alarm flag on match");
    pins(2'b01, "R9 alarm irq high");

    // R8 sticky
    wr(8'h44, 8'h00);
    rdm(8'h44, 8'h40, 8'h40, "R8 write 0 keeps alarm flag");
    wr(8'h44, 8'h40);
    rdm(8'h44, 8'h00, 8'h40, "R8 write 1 clears alarm flag");
    pins(2'b00, "R9 alarm irq low after clear");

    // R7 near miss, only the year differs
    wr(8'h34, 8'h01); wr(8'h20, 8'h07);
    ticks(8);
    rd(8'h00, 8'h07, "R7 reached near-miss second");
    rdm(8'h44, 8'h00, 8'h40, "R7 year mismatch blocks alarm");

    // R9 timer irq
    wr(8'h48, 8'h04);
    rd(8'h48, 8'h04, "R12 irq enable readback");
    pins(2'b10, "R9 timer irq high");
    wr(8'h48, 8'h00);
    pins(2'b00, "R9 timer irq masked");

    // R12 unmapped
    rd(8'h3C, 8'h00, "R12 unmapped 0x3C");
    rd(8'h4C, 8'h00, "R12 unmapped 0x4C");
    rd(8'h18, 8'h00, "R12 unmapped 0x18");

    // R2 / R5 stop
    wr(8'h40, 8'h00);
    ticks(8);
    rd(8'h00, 8'h07, "R2 stopped after run");
    rdm(8'h44, 8'h00, 8'h03, "R5 busy and run low when stopped");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule